// File: doc/BRIEF.md
# SPI Status Flags and Interrupt Controller

This block keeps the six status flags of a byte-oriented SPI peripheral and turns them into one interrupt request. The shift engine, baud generator and pin logic live elsewhere. They reach this block only as single-cycle event pulses: transmit buffer empty, receive buffer full, overrun, mode fault, CRC mismatch and wakeup. Each pulse sets its flag. Software reaches the flags through a small byte-wide register port with four locations: a control byte, an interrupt-enable byte, the status byte and the data byte.

The flags are cleared in three different ways. The two buffer flags clear as a side effect of data-register traffic. The CRC and wakeup flags clear when a zero is written to their bit. Overrun and mode fault clear only after a two-access sequence on the register port. A small tracker follows each sequence, and any unrelated access between the two steps cancels it. The interrupt output is the registered OR of every flag whose enable bit is set.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the flags are all 0 except the transmit-empty flag, which is 1. The interrupt enables, the control byte and the interrupt output are 0.
- R2: The status byte uses these bit positions: 0 receive-full, 1 transmit-empty, 2 wakeup, 3 CRC error, 4 mode fault, 5 overrun, 7:6 read as 0. A write to the status location (address 2) clears the wakeup flag and the CRC-error flag where the written bit is 0. Where the written bit is 1, that flag keeps its value. The write has no effect on the other four flags.
- R3: The overrun flag clears only in the cycle after a status read (address 2) that directly follows a read of the data location (address 3). Cycles with no access may come between the two reads.
- R4: The mode-fault flag clears only in the cycle after a write to the control location (address 0) that directly follows any read or write of the status location.
- R5: A source raises the interrupt only if both its enable bit and its flag are 1. The enable bit for each source sits at the same position as that source's flag in the status byte.
- R6: The interrupt-enable byte (address 1) stores bits 5:0 as written and reads them back, with bits 7:6 read as 0. Each enable bit can be changed without changing the others.
- R7: The interrupt output is registered. In each cycle it equals the OR of all enabled flags as they stood in the previous cycle.
- R8: If a flag's set event arrives in the same cycle as one of its clear conditions, the flag ends up set.
- R9: An access to any other location, or of any other kind, between the two steps of the overrun or mode-fault sequence cancels that sequence.
- R10: A write to the data location clears the transmit-empty flag. In the next cycle it presents the byte on the transmit output with a one-cycle load pulse. A read of the data location clears the receive-full flag and returns the receive byte input.
- R11: A write to the control location (address 0) stores the byte. The stored byte is driven on the control output and is read back at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register location: 0 control, 1 interrupt enable, 2 status, 3 data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe; ignored when wr_i is high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed location (combinational) |
| rx_byte_i | input | 8 | Received byte from the shift engine |
| tx_byte_o | output | 8 | Last byte written to the data location |
| tx_load_o | output | 1 | One-cycle pulse after a data write |
| ctrl1_o | output | 8 | Stored control byte |
| ev_txe_i | input | 1 | Transmit buffer empty event |
| ev_rxne_i | input | 1 | Receive buffer full event |
| ev_ovr_i | input | 1 | Overrun event |
| ev_modf_i | input | 1 | Mode fault event |
| ev_crcerr_i | input | 1 | CRC mismatch event |
| ev_wkup_i | input | 1 | Wakeup event |
| flags_o | output | 6 | Current flag vector, in the status bit order |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
A bad flag shows on flags_o one cycle after the edge where it went wrong, and on irq_o one cycle later if its enable is set. A sequence tracker that is armed or cancelled wrongly does not show until the second step of a sequence. At that point overrun or mode fault either clears when it should not or stays set when it should clear. For that reason the stimulus puts unrelated accesses, idle gaps and repeated first steps between the two halves of each sequence. The model is compared with flags_o, irq_o, ctrl1_o and the transmit outputs after every clock.

// File: rtl/spi_flag_pkg.sv
`timescale 1ns/1ps
package spi_flag_pkg;
  localparam int NFLAG    = 6;
  localparam int F_RXNE   = 0;
  localparam int F_TXE    = 1;
  localparam int F_WKUP   = 2;
  localparam int F_CRCERR = 3;
  localparam int F_MODF   = 4;
  localparam int F_OVR    = 5;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_IEN  = 2'd1,
    A_STAT = 2'd2,
    A_DATA = 2'd3
  } reg_addr_e;

  // Pending sources: enable and flag both high
  function automatic logic [NFLAG-1:0] pend_vec(input logic [NFLAG-1:0] en,
                                                input logic [NFLAG-1:0] fl);
    return en & fl;
  endfunction
endpackage

// File: rtl/spi_flag_bank.sv
`timescale 1ns/1ps
module spi_flag_bank #(
  parameter int              N       = 6,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        b <= RST_VAL[i];
      else if (set_i[i]) b <= 1'b1;
      else if (clr_i[i]) b <= 1'b0;
    end
    assign q_o[i] = b;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]);
  end
endmodule

// File: rtl/spi_flag_seq.sv
`timescale 1ns/1ps
module spi_flag_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,
  input  logic step1_i,
  input  logic step2_i,
  output logic fire_o
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (acc_i) armed <= step1_i;
  end

  assign fire_o = armed & step2_i;

  // R9
  seq_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !step1_i) |=> !fire_o);
endmodule

// File: rtl/spi_flag_irq.sv
`timescale 1ns/1ps
module spi_flag_irq
  import spi_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] en_i,
  input  logic [NFLAG-1:0] flag_i,
  output logic             irq_o
);
  logic pend_any;
  assign pend_any = |pend_vec(en_i, flag_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend_any;
  end

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_i & flag_i) == '0) |=> !irq_o);
  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_i & flag_i) != '0) |=> irq_o);
endmodule

// File: rtl/spi_flag_ctrl.sv
`timescale 1ns/1ps
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] rx_byte_i,
  output logic [DW-1:0] tx_byte_o,
  output logic          tx_load_o,
  output logic [DW-1:0] ctrl1_o,
  input  logic          ev_txe_i,
  input  logic          ev_rxne_i,
  input  logic          ev_ovr_i,
  input  logic          ev_modf_i,
  input  logic          ev_crcerr_i,
  input  logic          ev_wkup_i,
  output logic [NFLAG-1:0] flags_o,
  output logic          irq_o
);
  localparam logic [NFLAG-1:0] FLAG_RST = NFLAG'(1) << F_TXE;

  // Decoded access events, named for the checks
  logic acc, rd_eff;
  logic wr_ctrl, wr_ien, wr_stat, wr_data, rd_stat, rd_data;
  assign acc     = wr_i | rd_i;
  assign rd_eff  = rd_i & ~wr_i;
  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_ien  = wr_i && (addr_i == A_IEN);
  assign wr_stat = wr_i && (addr_i == A_STAT);
  assign wr_data = wr_i && (addr_i == A_DATA);
  assign rd_stat = rd_eff && (addr_i == A_STAT);
  assign rd_data = rd_eff && (addr_i == A_DATA);

  logic [NFLAG-1:0] set_vec, clr_vec, flags, ien_q;
  logic [DW-1:0]    ctrl_q, txb_q;
  logic             txl_q, ovr_fire, modf_fire;

  assign set_vec[F_RXNE]   = ev_rxne_i;
  assign set_vec[F_TXE]    = ev_txe_i;
  assign set_vec[F_WKUP]   = ev_wkup_i;
  assign set_vec[F_CRCERR] = ev_crcerr_i;
  assign set_vec[F_MODF]   = ev_modf_i;
  assign set_vec[F_OVR]    = ev_ovr_i;

  assign clr_vec[F_RXNE]   = rd_data;
  assign clr_vec[F_TXE]    = wr_data;
  assign clr_vec[F_WKUP]   = wr_stat & ~wdata_i[F_WKUP];
  assign clr_vec[F_CRCERR] = wr_stat & ~wdata_i[F_CRCERR];
  assign clr_vec[F_MODF]   = modf_fire;
  assign clr_vec[F_OVR]    = ovr_fire;

  spi_flag_seq u_ovr_seq (
    .clk(clk), .rst_n(rst_n), .acc_i(acc),
    .step1_i(rd_data), .step2_i(rd_stat), .fire_o(ovr_fire));

  spi_flag_seq u_modf_seq (
    .clk(clk), .rst_n(rst_n), .acc_i(acc),
    .step1_i(wr_stat | rd_stat), .step2_i(wr_ctrl), .fire_o(modf_fire));

  spi_flag_bank #(.N(NFLAG), .RST_VAL(FLAG_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .q_o(flags));

  spi_flag_irq u_irq (
    .clk(clk), .rst_n(rst_n), .en_i(ien_q), .flag_i(flags), .irq_o(irq_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      ctrl_q <= '0;
      txb_q  <= '0;
      txl_q  <= 1'b0;
    end else begin
      if (wr_ien)  ien_q  <= wdata_i[NFLAG-1:0];
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (wr_data) txb_q  <= wdata_i;
      txl_q <= wr_data;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_IEN:   rdata_o = DW'(ien_q);
      A_STAT:  rdata_o = DW'(flags);
      default: rdata_o = rx_byte_i;
    endcase
  end

  assign flags_o   = flags;
  assign ctrl1_o   = ctrl_q;
  assign tx_byte_o = txb_q;
  assign tx_load_o = txl_q;

  // R3
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[F_OVR]) |-> $past(rd_stat));
  // R4
  modf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[F_MODF]) |-> $past(wr_ctrl));
  // R2
  w1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata_i[F_CRCERR] && !ev_crcerr_i) |=>
      (flags[F_CRCERR] == $past(flags[F_CRCERR])));
  // R10
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (tx_load_o && !flags[F_TXE]) || $past(ev_txe_i));
endmodule

// File: tb/spi_flag_ctrl_bench.sv
`timescale 1ns/1ps
module spi_flag_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00, rxb = 8'h00;
  logic [5:0] ev = 6'h00;
  logic [7:0] rdata, txb, ctrl;
  logic txl, irq;
  logic [5:0] flags;

  always #2.5 clk = ~clk;

  spi_flag_ctrl u_spi_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_byte_i(rxb),
    .tx_byte_o(txb), .tx_load_o(txl), .ctrl1_o(ctrl),
    .ev_txe_i(ev[1]), .ev_rxne_i(ev[0]), .ev_ovr_i(ev[5]),
    .ev_modf_i(ev[4]), .ev_crcerr_i(ev[3]), .ev_wkup_i(ev[2]),
    .flags_o(flags), .irq_o(irq));

  int vecs = 0, fails = 0;
  string req = "R1";
  bit done = 0;

  // behavioural reference state
  logic [5:0] m_f = 6'b000010, m_ien = 6'h00;
  logic [7:0] m_ctrl = 8'h00, m_txb = 8'h00;
  logic m_irq = 0, m_txl = 0;
  int ovr_stage = 0, modf_stage = 0;

  task automatic compare();
    vecs++;
    if (flags !== m_f || irq !== m_irq || ctrl !== m_ctrl || txl !== m_txl ||
        (m_txl && txb !== m_txb)) begin
      fails++;
      $display("FAIL %s: flags=%b irq=%b ctrl=%h txl=%b txb=%h exp flags=%b irq=%b ctrl=%h txl=%b txb=%h",
               req, flags, irq, ctrl, txl, txb, m_f, m_irq, m_ctrl, m_txl, m_txb);
    end
  endtask

  task automatic step(input logic [1:0] a, input logic w, input logic r,
                      input logic [7:0] d, input logic [5:0] e);
    logic [7:0] exp_rd;
    logic [5:0] clr, nf;
    bit rde;
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d; ev = e; rxb = rxb * 8'd5 + 8'd17;
    #1;
    case (a)
      2'd0: exp_rd = m_ctrl;
      2'd1: exp_rd = {2'b00, m_ien};
      2'd2: exp_rd = {2'b00, m_f};
      default: exp_rd = rxb;
    endcase
    if (r) begin
      vecs++;
      if (rdata !== exp_rd) begin
        fails++;
        $display("FAIL %s: rdata=%h exp %h (addr %0d)", req, rdata, exp_rd, a);
      end
    end
    rde = r && !w;
    clr = 6'h00;
    if (rde && a == 2'd3) clr[0] = 1;
    if (w && a == 2'd3) clr[1] = 1;
    if (w && a == 2'd2) begin clr[2] = !d[2]; clr[3] = !d[3]; end
    if (modf_stage == 1 && w && a == 2'd0) clr[4] = 1;
    if (ovr_stage == 1 && rde && a == 2'd2) clr[5] = 1;
    if (w || r) begin
      ovr_stage  = (rde && a == 2'd3) ? 1 : 0;
      modf_stage = (a == 2'd2) ? 1 : 0;
    end
    nf = e | (m_f & ~clr);
    @(posedge clk);
    #1;
    m_irq = (m_ien & m_f) != 0;
    m_f = nf;
    if (w && a == 2'd1) m_ien = d[5:0];
    if (w && a == 2'd0) m_ctrl = d;
    m_txl = w && a == 2'd3;
    if (m_txl) m_txb = d;
    compare();
  endtask

  task automatic idle(); step(2'd0, 0, 0, 8'h00, 6'h00); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    req = "R1"; compare();
    step(2'd2, 0, 1, 8'h00, 6'h00);              // R1 status reads 0x02
    step(2'd1, 0, 1, 8'h00, 6'h00);

    req = "R11";
    step(2'd0, 1, 0, 8'hA5, 6'h00);
    step(2'd0, 0, 1, 8'h00, 6'h00);

    req = "R6";
    step(2'd1, 1, 0, 8'hD5, 6'h00);
    step(2'd1, 0, 1, 8'h00, 6'h00);
    step(2'd1, 1, 0, 8'h15 | 8'h02, 6'h00);      // flip one enable bit only
    step(2'd1, 0, 1, 8'h00, 6'h00);
    step(2'd1, 1, 0, 8'h00, 6'h00);

    req = "R10";
    step(2'd3, 1, 0, 8'h3C, 6'h00);
    idle();
    step(2'd0, 0, 0, 8'h00, 6'h02);
    step(2'd0, 0, 0, 8'h00, 6'h01);
    step(2'd3, 0, 1, 8'h00, 6'h00);
    step(2'd2, 0, 1, 8'h00, 6'h00);

    req = "R2";
    step(2'd0, 0, 0, 8'h00, 6'h0C);
    step(2'd2, 1, 0, 8'hFF, 6'h00);
    step(2'd2, 1, 0, 8'hF7, 6'h00);
    step(2'd2, 1, 0, 8'h00, 6'h00);
    step(2'd2, 0, 1, 8'h00, 6'h00);

    req = "R8";
    step(2'd2, 1, 0, 8'h00, 6'h08);
    step(2'd3, 1, 0, 8'h11, 6'h02);
    step(2'd2, 1, 0, 8'h00, 6'h00);

    req = "R3";
    step(2'd0, 0, 0, 8'h00, 6'h20);
    step(2'd2, 0, 1, 8'h00, 6'h00);
    step(2'd3, 0, 1, 8'h00, 6'h00);
    idle(); idle();
    step(2'd2, 0, 1, 8'h00, 6'h00);

    req = "R9";
    step(2'd0, 0, 0, 8'h00, 6'h30);
    step(2'd3, 0, 1, 8'h00, 6'h00);
    step(2'd0, 1, 0, 8'h5A, 6'h00);
    step(2'd2, 0, 1, 8'h00, 6'h00);
    step(2'd2, 0, 1, 8'h00, 6'h00);
    step(2'd3, 0, 1, 8'h00, 6'h00);
    step(2'd0, 1, 0, 8'h5B, 6'h00);
    step(2'd3, 0, 1, 8'h00, 6'h00);
    step(2'd2, 0, 1, 8'h00, 6'h00);

    req = "R4";
    step(2'd0, 0, 0, 8'h00, 6'h10);
    step(2'd0, 1, 0, 8'h01, 6'h00);
    step(2'd2, 1, 0, 8'hFF, 6'h00);
    idle();
    step(2'd0, 1, 0, 8'h02, 6'h00);
    step(2'd2, 0, 1, 8'h00, 6'h00);

    req = "R5";
    for (int i = 0; i < 6; i++) begin
      step(2'd1, 1, 0, 8'(1 << i), 6'h00);
      step(2'd0, 0, 0, 8'h00, 6'(6'h3F & ~(6'd1 << i)));
      idle();
      step(2'd0, 0, 0, 8'h00, 6'(1 << i));
      idle(); idle();
    end

    req = "R7";
    for (int k = 0; k < 400; k++) begin
      logic [7:0] s;
      s = 8'(k * 37 + 11) ^ 8'(k >> 2);
      step(s[1:0], s[2], s[3], 8'(k * 73), (s[7:5] == 3'd0) ? s[5:0] : 6'h00);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule